// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is the slave side of a small byte-wide serial nonvolatile memory with 512 bytes, held here in a register array. A host selects it by pulling `cs_n` low and then clocks bytes in on `si` and out on `so`. Transfers are MSB first, with `si` sampled on rising `sck` and `so` updated on falling `sck` (clock idle low). The block never drives `sck`. The first byte of every frame is a command. A read or write command carries the ninth address bit, and the next byte carries the low eight address bits.

Writes are gated in three ways: the `wp_n` pin, a write-enable latch that software sets and clears, and a two-bit block-protection field in the status register. A committed page write starts a busy countdown that stands in for self-timed programming. While the countdown runs, only status reads are served. `hold_n` pauses a frame part way through without losing its position. All pins are treated as synchronous to `clk` and are sampled by it. `so_oe` is the tri-state enable for the `so` pad.

Top module: `seprom_spi`

## Requirements
- R1: After reset `so_oe` is low, and a status read returns 0x00. The status byte is {4'b0, bp[1:0], wel, busy}.
- R2: While `cs_n` is high, `so_oe` stays low and activity on `sck` and `si` changes no state.
- R3: The read command is 0000_A011, where bit 3 is address bit 8. It is followed by the byte A7..A0. Data bytes then come out MSB first, from consecutive addresses, and the address wraps from 0x1FF to 0x000.
- R4: Command 0x06 sets the write-enable latch (status bit 1) and 0x04 clears it. The end of a write's busy countdown also clears it. A write command (0000_A010) sent while the latch is clear is ignored.
- R5: Write data bytes fill one 8-byte page, and the low 3 address bits wrap inside that page. The page is committed only if `cs_n` rises after a whole number of data bytes, with at least one data byte.
- R6: A commit starts a countdown of BUSY_CYCLES clocks, during which status bit 0 reads 1. Only the status read (0x05) is served while the countdown runs; a read frame leaves `so_oe` low and a write enable is lost.
- R7: Status bits 3:2 set the protection level: 0 protects nothing, 1 protects 0x180–0x1FF, 2 protects 0x100–0x1FF, and 3 protects every address. Bytes aimed at protected addresses are discarded.
- R8: With `wp_n` low, write and status-write commands are refused. If `wp_n` is low at any point after a write command in a frame, that frame's commit is cancelled.
- R9: After an unrecognised command, the rest of the frame is ignored and `so_oe` stays low. The next frame works normally.
- R10: `hold_n` takes effect only while `sck` is low. While paused, `so_oe` is low and `sck`/`si` are ignored. On release, the transfer continues from the same bit and address.
- R11: The status write is command 0x01 followed by one byte. When `cs_n` rises on a byte boundary, bits 3:2 of that byte load the protection field and the write-enable latch clears. This needs the latch set and `wp_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the slave |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out of the slave |
| so_oe | output | 1 | Output enable for the `so` pad |

## Verification
The assertions assume that `sck`, `cs_n`, `hold_n` and `wp_n` change away from `clk` edges, and that each `sck` level is held for at least two clocks. Under these conditions every `sck` transition is seen as exactly one edge. The assertions also assume the host changes `hold_n` only while `sck` is low. The stimulus drives every pin on the falling edge of `clk`, keeps each `sck` phase three clocks long, and moves `hold_n` only during a low phase. This keeps the checks on the frozen bit counter and on the write-latch/busy handshake meaningful.

// File: rtl/seprom_pkg.sv
package seprom_pkg;

  localparam int AW = 9;

  typedef enum logic [2:0] {
    OP_BAD, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
  } op_e;

  typedef enum logic [2:0] {
    S_OP, S_ADDR, S_RD, S_WDATA, S_SROUT, S_SRIN, S_SRDONE, S_LOCK
  } st_e;

  // Command decode; bit 3 is only legal as address bit 8 on read/write.
  function automatic op_e op_decode(input logic [7:0] b);
    if (b[7:4] != 4'h0) return OP_BAD;
    case (b[2:0])
      3'b110:  return b[3] ? OP_BAD : OP_WREN;
      3'b100:  return b[3] ? OP_BAD : OP_WRDI;
      3'b101:  return b[3] ? OP_BAD : OP_RDSR;
      3'b001:  return b[3] ? OP_BAD : OP_WRSR;
      3'b011:  return OP_READ;
      3'b010:  return OP_WRITE;
      default: return OP_BAD;
    endcase
  endfunction

  // Protection from the top two address bits and the level field.
  function automatic logic addr_locked(input logic [1:0] top2, input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return top2 == 2'b11;
      2'd2:    return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic [1:0] lvl, input logic wel,
                                             input logic busy);
    return {4'b0000, lvl, wel, busy};
  endfunction

endpackage

// File: rtl/seprom_link.sv
module seprom_link (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       hold_n,
  input  logic       tx_want,
  input  logic [7:0] tx_data,
  output logic       rx_done,
  output logic [7:0] rx_byte,
  output logic [2:0] bit_idx,
  output logic       tx_take,
  output logic       so_bit,
  output logic       held
);
  logic       sck_q;
  logic [6:0] sh;
  logic [7:0] tx;
  logic       rise, fall;

  assign rise    = sck & ~sck_q & ~held & ~cs_n;
  assign fall    = ~sck & sck_q & ~held & ~cs_n;
  assign tx_take = fall && (bit_idx == 3'd0) && tx_want;
  assign so_bit  = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      sh      <= '0;
      tx      <= '0;
      rx_byte <= '0;
      rx_done <= 1'b0;
      bit_idx <= '0;
      held    <= 1'b0;
    end else begin
      sck_q   <= sck;
      rx_done <= 1'b0;
      if (cs_n) begin
        bit_idx <= '0;
        held    <= 1'b0;
        tx      <= '0;
      end else begin
        if (!sck) held <= !hold_n;
        if (rise) begin
          sh      <= {sh[5:0], si};
          bit_idx <= 3'(bit_idx + 3'd1);
          if (bit_idx == 3'd7) begin
            rx_byte <= {sh, si};
            rx_done <= 1'b1;
          end
        end
        if (fall) tx <= tx_take ? tx_data : {tx[6:0], 1'b0};
      end
    end
  end

  // R10: a paused link keeps its bit position
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    held |=> $stable(bit_idx));

endmodule

// File: rtl/seprom_ctrl.sv
module seprom_ctrl
  import seprom_pkg::*;
#(
  parameter int PAGE = 8,
  localparam int PW = $clog2(PAGE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    wp_n,
  input  logic                    rx_done,
  input  logic [7:0]              rx_byte,
  input  logic [2:0]              bit_idx,
  input  logic                    held,
  input  logic                    tx_take,
  input  logic                    busy,
  input  logic                    busy_done,
  input  logic [7:0]              rd_data,
  output logic                    tx_want,
  output logic [7:0]              tx_data,
  output logic                    so_oe,
  output logic [AW-1:0]           rd_addr,
  output logic                    commit_go,
  output logic [AW-PW-1:0]        commit_base,
  output logic [PAGE-1:0][7:0]    commit_data,
  output logic [PAGE-1:0]         commit_mask,
  output logic [1:0]              bp
);
  st_e           st;
  logic          cs_q, wel, a8, wr, got, abort;
  logic [AW-1:0] addr;
  logic [7:0]    sr_new;
  logic          cs_rise, sr_go, wframe;
  op_e           op;

  assign cs_rise     = cs_n & ~cs_q;
  assign op          = op_decode(rx_byte);
  assign wframe      = (st == S_ADDR && wr) || st == S_WDATA;
  assign commit_go   = cs_rise && st == S_WDATA && bit_idx == 3'd0 && got && !abort && wp_n;
  assign sr_go       = cs_rise && st == S_SRDONE && bit_idx == 3'd0 && wp_n && wel;
  assign commit_base = addr[AW-1:PW];
  assign rd_addr     = addr;
  assign tx_want     = (st == S_RD) || (st == S_SROUT);
  assign tx_data     = (st == S_SROUT) ? status_byte(bp, wel, busy) : rd_data;
  assign so_oe       = tx_want && !held && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_OP;
      cs_q        <= 1'b1;
      wel         <= 1'b0;
      bp          <= 2'd0;
      a8          <= 1'b0;
      wr          <= 1'b0;
      got         <= 1'b0;
      abort       <= 1'b0;
      addr        <= '0;
      sr_new      <= '0;
      commit_mask <= '0;
    end else begin
      cs_q <= cs_n;
      if (busy_done) wel <= 1'b0;
      if (sr_go) begin
        bp  <= sr_new[3:2];
        wel <= 1'b0;
      end
      if (cs_n) begin
        st    <= S_OP;
        got   <= 1'b0;
        abort <= 1'b0;
      end else begin
        if (wframe && !wp_n) abort <= 1'b1;
        if (tx_take && st == S_RD) addr <= AW'(addr + 1'b1);
        if (rx_done) begin
          case (st)
            S_OP: begin
              a8 <= rx_byte[3];
              wr <= (op == OP_WRITE);
              st <= S_LOCK;
              case (op)
                OP_WREN:  if (!busy) wel <= 1'b1;
                OP_WRDI:  if (!busy) wel <= 1'b0;
                OP_RDSR:  st <= S_SROUT;
                OP_WRSR:  if (!busy && wel && wp_n) st <= S_SRIN;
                OP_READ:  if (!busy) st <= S_ADDR;
                OP_WRITE: if (!busy && wel && wp_n) st <= S_ADDR;
                default:  st <= S_LOCK;
              endcase
            end
            S_ADDR: begin
              addr        <= {a8, rx_byte};
              st          <= wr ? S_WDATA : S_RD;
              commit_mask <= '0;
              got         <= 1'b0;
            end
            S_WDATA: begin
              commit_data[addr[PW-1:0]] <= rx_byte;
              commit_mask[addr[PW-1:0]] <= 1'b1;
              got                       <= 1'b1;
              addr <= {addr[AW-1:PW], PW'(addr[PW-1:0] + 1'b1)};
            end
            S_SRIN: begin
              sr_new <= rx_byte;
              st     <= S_SRDONE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R6: no commit is issued into a running countdown
  p_no_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !busy);
  // R4: the end of the countdown leaves the latch clear
  p_wel_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R11: the protection field moves only out of an enabled state
  p_sr_needs_wel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $past(wel));

endmodule

// File: rtl/seprom_array.sv
module seprom_array
  import seprom_pkg::*;
#(
  parameter int PAGE        = 8,
  parameter int BUSY_CYCLES = 1250000,
  localparam int PW    = $clog2(PAGE),
  localparam int CW    = $clog2(BUSY_CYCLES + 1),
  localparam int DEPTH = 1 << AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit_go,
  input  logic [AW-PW-1:0]     commit_base,
  input  logic [PAGE-1:0][7:0] commit_data,
  input  logic [PAGE-1:0]      commit_mask,
  input  logic [1:0]           bp,
  input  logic [AW-1:0]        rd_addr,
  output logic [7:0]           rd_data,
  output logic                 busy,
  output logic                 busy_done
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt;

  assign rd_data   = mem[rd_addr];
  assign busy      = cnt != '0;
  assign busy_done = cnt == CW'(1);

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE; i++) begin
      if (commit_go && commit_mask[i] &&
          !addr_locked(commit_base[AW-PW-1 -: 2], bp))
        mem[{commit_base, PW'(i)}] <= commit_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (commit_go) cnt <= CW'(BUSY_CYCLES);
    else if (busy)      cnt <= CW'(cnt - 1'b1);
  end

  // R6: a commit always opens a busy window
  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

endmodule

// File: rtl/seprom_spi.sv
module seprom_spi #(
  parameter int PAGE        = 8,
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  import seprom_pkg::*;
  localparam int PW = $clog2(PAGE);

  logic                 rx_done, tx_take, tx_want, held, so_bit;
  logic [7:0]           rx_byte, tx_data, rd_data;
  logic [2:0]           bit_idx;
  logic                 busy, busy_done, commit_go;
  logic [AW-1:0]        rd_addr;
  logic [AW-PW-1:0]     commit_base;
  logic [PAGE-1:0][7:0] commit_data;
  logic [PAGE-1:0]      commit_mask;
  logic [1:0]           bp;

  seprom_link u_link (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .tx_want(tx_want), .tx_data(tx_data), .rx_done(rx_done), .rx_byte(rx_byte),
    .bit_idx(bit_idx), .tx_take(tx_take), .so_bit(so_bit), .held(held)
  );

  seprom_ctrl #(.PAGE(PAGE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .rx_done(rx_done),
    .rx_byte(rx_byte), .bit_idx(bit_idx), .held(held), .tx_take(tx_take),
    .busy(busy), .busy_done(busy_done), .rd_data(rd_data), .tx_want(tx_want),
    .tx_data(tx_data), .so_oe(so_oe), .rd_addr(rd_addr), .commit_go(commit_go),
    .commit_base(commit_base), .commit_data(commit_data),
    .commit_mask(commit_mask), .bp(bp)
  );

  seprom_array #(.PAGE(PAGE), .BUSY_CYCLES(BUSY_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_n), .commit_go(commit_go), .commit_base(commit_base),
    .commit_data(commit_data), .commit_mask(commit_mask), .bp(bp),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .busy_done(busy_done)
  );

  assign so = so_oe & so_bit;

  // R2: a deselected slave never drives the pad
  p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_oe);
  // R10: a paused link releases the pad
  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);

endmodule

// File: tb/seprom_spi_test.sv
`timescale 1ns/1ps
module seprom_spi_test;
  localparam int H = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int   total = 0, bad = 0, cyc = 0;
  logic seen_oe;

  seprom_spi #(.PAGE(8), .BUSY_CYCLES(400)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .so(so), .so_oe(so_oe));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic r);
    @(negedge clk) si = b;
    idle(H);
    r = so;
    if (so_oe) seen_oe = 1'b1;
    sck = 1'b1;
    idle(H);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i]);
  endtask

  task automatic sel();
    @(negedge clk) cs_n = 1'b0;
    seen_oe = 1'b0;
    idle(H);
  endtask

  task automatic desel();
    idle(H);
    cs_n = 1'b1;
    idle(4 * H);
  endtask

  task automatic cmd1(input logic [7:0] c);
    logic [7:0] r;
    sel(); xfer(c, r); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel(); xfer(8'h01, r); xfer(v, r); desel();
  endtask

  task automatic wr3(input logic [8:0] a, input int n, input logic [7:0] b0,
                     input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] r;
    sel();
    xfer({4'h0, a[8], 3'b010}, r);
    xfer(a[7:0], r);
    if (n > 0) xfer(b0, r);
    if (n > 1) xfer(b1, r);
    if (n > 2) xfer(b2, r);
    desel();
  endtask

  task automatic rd2(input logic [8:0] a, output logic [7:0] r0, output logic [7:0] r1);
    logic [7:0] r;
    sel();
    xfer({4'h0, a[8], 3'b011}, r);
    xfer(a[7:0], r);
    xfer(8'h00, r0);
    xfer(8'h00, r1);
    desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic put(input logic [8:0] a, input logic [7:0] v);
    cmd1(8'h06); wr3(a, 1, v, 8'h00, 8'h00); wait_ready();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 so_oe after reset", so_oe, 0);
    rdsr(s);
    chk("R1 status after reset", s, 8'h00);
  endtask

  task automatic t_deselect();
    logic [7:0] s;
    int oe_hits = 0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) si = ~i[0];
      idle(H); if (so_oe) oe_hits++;
      sck = 1'b1; idle(H); if (so_oe) oe_hits++;
      sck = 1'b0;
    end
    chk("R2 so_oe while deselected", oe_hits, 0);
    rdsr(s);
    chk("R2 status unchanged by deselected clocks", s, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] s;
    cmd1(8'h06); rdsr(s);
    chk("R4 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s);
    chk("R4 latch cleared", s, 8'h00);
    wr3(9'h040, 1, 8'h5C, 8'h00, 8'h00); rdsr(s);
    chk("R4 write without latch starts nothing", s, 8'h00);
  endtask

  task automatic t_page();
    logic [7:0] s, r0, r1;
    cmd1(8'h06);
    wr3(9'h106, 3, 8'h11, 8'h22, 8'h33);
    rdsr(s);
    chk("R6 busy and latch during countdown", s, 8'h03);
    wait_ready(); rdsr(s);
    chk("R4 latch cleared after countdown", s, 8'h00);
    rd2(9'h106, r0, r1);
    chk("R5 page byte 6", r0, 8'h11);
    chk("R5 page byte 7", r1, 8'h22);
    rd2(9'h100, r0, r1);
    chk("R5 wrap inside page", r0, 8'h33);
    put(9'h006, 8'h44);
    rd2(9'h006, r0, r1);
    chk("R3 low half address", r0, 8'h44);
    rd2(9'h106, r0, r1);
    chk("R3 address bit 8 from command", r0, 8'h11);
    put(9'h1FF, 8'h5A);
    put(9'h000, 8'hA5);
    rd2(9'h1FF, r0, r1);
    chk("R3 read at top", r0, 8'h5A);
    chk("R3 read wraps to zero", r1, 8'hA5);
  endtask

  task automatic t_ignore();
    logic [7:0] s, r0, r1;
    wr3(9'h006, 1, 8'h99, 8'h00, 8'h00); rdsr(s);
    chk("R4 ignored write no busy", s, 8'h00);
    rd2(9'h006, r0, r1);
    chk("R4 ignored write keeps data", r0, 8'h44);
  endtask

  task automatic t_busy();
    logic [7:0] s, r0, r1;
    cmd1(8'h06);
    wr3(9'h010, 1, 8'h77, 8'h00, 8'h00);
    rd2(9'h006, r0, r1);
    chk("R6 read during countdown keeps SO released", seen_oe, 0);
    cmd1(8'h06);
    wait_ready(); rdsr(s);
    chk("R6 enable during countdown dropped", s, 8'h00);
    rd2(9'h010, r0, r1);
    chk("R6 committed byte", r0, 8'h77);
  endtask

  task automatic t_partial();
    logic [7:0] s, r;
    logic b;
    cmd1(8'h06);
    sel();
    xfer(8'h02, r); xfer(8'h20, r); xfer(8'h66, r);
    sbit(1'b1, b); sbit(1'b0, b); sbit(1'b1, b);
    desel();
    rdsr(s);
    chk("R5 no commit off byte boundary", s, 8'h02);
    sel(); xfer(8'h02, r); xfer(8'h20, r); desel();
    rdsr(s);
    chk("R5 no commit without data", s, 8'h02);
    cmd1(8'h04);
  endtask

  task automatic t_protect();
    logic [7:0] s, r0, r1;
    put(9'h180, 8'h12);
    cmd1(8'h06); wrsr(8'h04); rdsr(s);
    chk("R11 level 1 loaded latch cleared", s, 8'h04);
    put(9'h180, 8'hEE);
    put(9'h17F, 8'h56);
    rd2(9'h17F, r0, r1);
    chk("R7 level 1 below quarter writable", r0, 8'h56);
    chk("R7 level 1 top quarter kept", r1, 8'h12);
    cmd1(8'h06); wrsr(8'h08);
    put(9'h100, 8'hEE);
    put(9'h0FF, 8'h34);
    rd2(9'h0FF, r0, r1);
    chk("R7 level 2 lower half writable", r0, 8'h34);
    chk("R7 level 2 upper half kept", r1, 8'h33);
    cmd1(8'h06); wrsr(8'h0C);
    put(9'h000, 8'hEE);
    rd2(9'h000, r0, r1);
    chk("R7 level 3 whole array kept", r0, 8'hA5);
    cmd1(8'h06); wrsr(8'h00); rdsr(s);
    chk("R11 level cleared", s, 8'h00);
  endtask

  task automatic t_wp();
    logic [7:0] s, r, r0, r1;
    logic b;
    wp_n = 1'b0;
    cmd1(8'h06);
    wr3(9'h006, 1, 8'h99, 8'h00, 8'h00); rdsr(s);
    chk("R8 write refused with pin low", s, 8'h02);
    wrsr(8'h08); rdsr(s);
    chk("R8 status write refused with pin low", s, 8'h02);
    @(negedge clk) wp_n = 1'b1;
    sel();
    xfer(8'h02, r); xfer(8'h06, r);
    for (int i = 7; i >= 0; i--) begin
      sbit(i[0], b);
      if (i == 4) begin wp_n = 1'b0; idle(2); wp_n = 1'b1; end
    end
    desel();
    rdsr(s);
    chk("R8 pin pulse aborts commit", s, 8'h02);
    rd2(9'h006, r0, r1);
    chk("R8 aborted byte unchanged", r0, 8'h44);
    cmd1(8'h04);
  endtask

  task automatic t_invalid();
    logic [7:0] s, r;
    sel(); xfer(8'hFF, r); xfer(8'h05, r); xfer(8'h00, r); desel();
    chk("R9 SO released after bad command", seen_oe, 0);
    rdsr(s);
    chk("R9 next frame served", seen_oe, 1);
    chk("R9 next frame status", s, 8'h00);
  endtask

  task automatic t_hold();
    logic [7:0] r, d, d2;
    logic b;
    sel();
    xfer(8'h0B, r); xfer(8'h06, r);
    for (int i = 7; i >= 5; i--) begin sbit(1'b0, b); d[i] = b; end
    @(negedge clk) hold_n = 1'b0;
    idle(4);
    chk("R10 SO released while paused", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si = 1'b1; sck = 1'b1; idle(H); sck = 1'b0; idle(H);
    end
    hold_n = 1'b1;
    idle(2);
    for (int i = 4; i >= 0; i--) begin sbit(1'b0, b); d[i] = b; end
    xfer(8'h00, d2);
    desel();
    chk("R10 byte resumes at same bit", d, 8'h11);
    chk("R10 address kept across pause", d2, 8'h22);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_deselect();
    t_enable();
    t_page();
    t_ignore();
    t_busy();
    t_partial();
    t_protect();
    t_wp();
    t_invalid();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule